// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a two-port byte memory in which each port owns one mailbox location near the top of the address space. When the opposite port writes a port's mailbox, that port's interrupt output goes active low. The owning port clears its interrupt by reading the mailbox (chip enable and output enable both low); the level on its read/write input does not matter for the clear. The mailbox bytes are ordinary storage, so the sender can leave a message there and the receiver reads it and clears its interrupt in one access.

Both ports run on one clock and can start an access in every cycle. Each port has active-low chip enable, output enable and read/write controls, a busy input that blocks that port's writes and flag actions, an address, write data, registered read data and a read-valid strobe. The default geometry is 2048 words of 8 bits. The left mailbox is the second-highest address (0x7FE) and the right mailbox is the highest address (0x7FF).

Top module: `dpmbox_top`

## Requirements
- R1: After reset both interrupt outputs are high (inactive), both read-valid outputs are low and both read-data outputs are zero.
- R2: A read (chip enable low, output enable low, read/write high) returns the stored byte on that port's read data one clock later, with read-valid high. In a cycle after a non-read, read-valid is low and read data is zero.
- R3: A port writes the array only when its chip enable and its read/write input are both low. Output enable has no effect on a write. With chip enable high, nothing is stored.
- R4: A write attempted while that port's busy input is low (active) leaves the memory unchanged.
- R5: A right-port write to address 0x7FE drives the left interrupt low on the next clock.
- R6: A left-port access to 0x7FE with chip enable and output enable low drives the left interrupt high again on the next clock, whether its read/write input is high or low.
- R7: A left-port write to 0x7FF drives the right interrupt low on the next clock. A right-port access to 0x7FF with chip enable and output enable low clears it.
- R8: If the busy input of the port that would set or clear a flag is low, that flag keeps its value.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (low).
- R10: The bytes at 0x7FE and 0x7FF are read and written like any other location.
- R11: A write from one port and a read from the other to the same address in the same cycle return the old byte to the reader.
- R12: When both ports write the same address in the same cycle, the left port's byte is kept.
- R13: A port that writes its own mailbox does not raise its own interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Asynchronous reset, active low |
| lCeN | input | 1 | Left chip enable, active low |
| lOeN | input | 1 | Left output enable, active low |
| lRwN | input | 1 | Left read/write: high reads, low writes |
| lBusyN | input | 1 | Left busy, active low; blocks left writes and flag actions |
| lAddr | input | 11 | Left address |
| lWrData | input | 8 | Left write data |
| lRdData | output | 8 | Left read data, registered |
| lRdValid | output | 1 | Left read data valid |
| lIntN | output | 1 | Left interrupt, active low |
| rCeN | input | 1 | Right chip enable, active low |
| rOeN | input | 1 | Right output enable, active low |
| rRwN | input | 1 | Right read/write: high reads, low writes |
| rBusyN | input | 1 | Right busy, active low; blocks right writes and flag actions |
| rAddr | input | 11 | Right address |
| rWrData | input | 8 | Right write data |
| rRdData | output | 8 | Right read data, registered |
| rRdValid | output | 1 | Right read data valid |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
Every result of this block is due exactly one clock after the cycle that presents the stimulus. Read data and read-valid come from one register stage, and each interrupt flag is a single register updated by the set or clear decoded in that cycle. A write becomes visible to a read presented in the following cycle, so its data appears one further clock later. The bench drives a cycle's inputs just after a rising edge and samples the outputs just after the next rising edge. It therefore always compares the value produced by the registers at the single edge between stimulus and check.

// File: rtl/dpmbox_pkg.sv
package dpmbox_pkg;

  // Strobes decoded by the control for the datapath, one set per port.
  typedef struct packed {
    logic wrEn;   // gated write to the array
    logic rdEn;   // registered read request
  } portStrobe_t;

  typedef struct packed {
    portStrobe_t left;
    portStrobe_t right;
  } memStrobe_t;

endpackage

// File: rtl/dpmbox_flag.sv
module dpmbox_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setReq,
  input  logic clrReq,
  output logic flagN
);

  // Active-low flag; set overrides clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagN <= 1'b1;
    else if (setReq) flagN <= 1'b0;
    else if (clrReq) flagN <= 1'b1;
  end

endmodule

// File: rtl/dpmbox_ctrl.sv
module dpmbox_ctrl
  import dpmbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lRwN,
  input  logic              lBusyN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rRwN,
  input  logic              rBusyN,
  input  logic [ADDR_W-1:0] rAddr,
  output memStrobe_t        strobe,
  output logic              lIntN,
  output logic              rIntN
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MBOX_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] MBOX_R = ADDR_W'(DEPTH - 1);

  logic lWrGated, rWrGated;
  logic lAccess, rAccess;
  logic setL, clrL, setR, clrR;

  always_comb begin
    lWrGated = !lCeN && !lRwN && lBusyN;
    rWrGated = !rCeN && !rRwN && rBusyN;
    lAccess  = !lCeN && !lOeN && lBusyN;
    rAccess  = !rCeN && !rOeN && rBusyN;

    strobe.left.wrEn  = lWrGated;
    strobe.left.rdEn  = !lCeN && !lOeN && lRwN;
    strobe.right.wrEn = rWrGated;
    strobe.right.rdEn = !rCeN && !rOeN && rRwN;

    // Cross-port set, owner clear.
    setL = rWrGated && (rAddr == MBOX_L);
    clrL = lAccess  && (lAddr == MBOX_L);
    setR = lWrGated && (lAddr == MBOX_R);
    clrR = rAccess  && (rAddr == MBOX_R);
  end

  dpmbox_flag u_flagL (
    .clk    (clk),
    .rstN   (rstN),
    .setReq (setL),
    .clrReq (clrL),
    .flagN  (lIntN)
  );

  dpmbox_flag u_flagR (
    .clk    (clk),
    .rstN   (rstN),
    .setReq (setR),
    .clrReq (clrR),
    .flagN  (rIntN)
  );

endmodule

// File: rtl/dpmbox_datapath.sv
module dpmbox_datapath
  import dpmbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right write first so a same-address left write lands last and wins.
  always_ff @(posedge clk) begin
    if (strobe.right.wrEn) mem[rAddr] <= rWrData;
    if (strobe.left.wrEn)  mem[lAddr] <= lWrData;
  end

  // Reads sample the array before this edge's writes: old data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdData  <= '0;
      lRdValid <= 1'b0;
      rRdData  <= '0;
      rRdValid <= 1'b0;
    end else begin
      lRdValid <= strobe.left.rdEn;
      rRdValid <= strobe.right.rdEn;
      lRdData  <= strobe.left.rdEn  ? mem[lAddr] : '0;
      rRdData  <= strobe.right.rdEn ? mem[rAddr] : '0;
    end
  end

endmodule

// File: rtl/dpmbox_top.sv
module dpmbox_top
  import dpmbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lRwN,
  input  logic              lBusyN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  output logic              lIntN,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rRwN,
  input  logic              rBusyN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid,
  output logic              rIntN
);

  memStrobe_t strobe;

  dpmbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lCeN   (lCeN),
    .lOeN   (lOeN),
    .lRwN   (lRwN),
    .lBusyN (lBusyN),
    .lAddr  (lAddr),
    .rCeN   (rCeN),
    .rOeN   (rOeN),
    .rRwN   (rRwN),
    .rBusyN (rBusyN),
    .rAddr  (rAddr),
    .strobe (strobe),
    .lIntN  (lIntN),
    .rIntN  (rIntN)
  );

  dpmbox_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lAddr    (lAddr),
    .lWrData  (lWrData),
    .rAddr    (rAddr),
    .rWrData  (rWrData),
    .lRdData  (lRdData),
    .lRdValid (lRdValid),
    .rRdData  (rRdData),
    .rRdValid (rRdValid)
  );

endmodule

// File: rtl/dpmbox_checker.sv
module dpmbox_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lCeN,
  input logic              lOeN,
  input logic              lRwN,
  input logic              lBusyN,
  input logic [ADDR_W-1:0] lAddr,
  input logic [DATA_W-1:0] lRdData,
  input logic              lRdValid,
  input logic              lIntN,
  input logic              rCeN,
  input logic              rOeN,
  input logic              rRwN,
  input logic              rBusyN,
  input logic [ADDR_W-1:0] rAddr,
  input logic [DATA_W-1:0] rRdData,
  input logic              rRdValid,
  input logic              rIntN
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'(DEPTH - 1);

  logic setLeft, setRight, touchLeft, touchRight;
  assign setLeft    = !rCeN && !rRwN && rBusyN && (rAddr == BOX_L);
  assign setRight   = !lCeN && !lRwN && lBusyN && (lAddr == BOX_R);
  assign touchLeft  = !lCeN && !lOeN && (lAddr == BOX_L);
  assign touchRight = !rCeN && !rOeN && (rAddr == BOX_R);

  AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rstN)
    setLeft |=> !lIntN); // R5

  AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (touchLeft && lBusyN && !setLeft) |=> lIntN); // R6

  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rstN)
    setRight |=> !rIntN); // R7

  AST_RIGHT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (touchRight && rBusyN && !setRight) |=> rIntN); // R7

  AST_LEFT_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!setLeft && !(touchLeft && lBusyN)) |=> $stable(lIntN)); // R8

  AST_RIGHT_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!setRight && !(touchRight && rBusyN)) |=> $stable(rIntN)); // R8

  AST_LEFT_IDLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !(!lCeN && !lOeN && lRwN) |=> (!lRdValid && lRdData == '0)); // R2

  AST_RIGHT_READ_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (!rCeN && !rOeN && rRwN) |=> rRdValid); // R2

endmodule

bind dpmbox_top dpmbox_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lCeN     (lCeN),
  .lOeN     (lOeN),
  .lRwN     (lRwN),
  .lBusyN   (lBusyN),
  .lAddr    (lAddr),
  .lRdData  (lRdData),
  .lRdValid (lRdValid),
  .lIntN    (lIntN),
  .rCeN     (rCeN),
  .rOeN     (rOeN),
  .rRwN     (rRwN),
  .rBusyN   (rBusyN),
  .rAddr    (rAddr),
  .rRdData  (rRdData),
  .rRdValid (rRdValid),
  .rIntN    (rIntN)
);

// File: tb/dpmbox_top_tb.sv
module dpmbox_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lCeN, lOeN, lRwN, lBusyN;
  logic [10:0] lAddr;
  logic [7:0]  lWrData;
  logic [7:0]  lRdData;
  logic        lRdValid, lIntN;
  logic        rCeN, rOeN, rRwN, rBusyN;
  logic [10:0] rAddr;
  logic [7:0]  rWrData;
  logic [7:0]  rRdData;
  logic        rRdValid, rIntN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dpmbox_top u_dut (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lOeN(lOeN), .lRwN(lRwN), .lBusyN(lBusyN),
    .lAddr(lAddr), .lWrData(lWrData), .lRdData(lRdData),
    .lRdValid(lRdValid), .lIntN(lIntN),
    .rCeN(rCeN), .rOeN(rOeN), .rRwN(rRwN), .rBusyN(rBusyN),
    .rAddr(rAddr), .rWrData(rWrData), .rRdData(rRdData),
    .rRdValid(rRdValid), .rIntN(rIntN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Advance one clock; outputs then reflect the previous cycle's inputs.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleL();
    lCeN = 1; lOeN = 1; lRwN = 1; lBusyN = 1; lAddr = '0; lWrData = '0;
  endtask

  task automatic idleR();
    rCeN = 1; rOeN = 1; rRwN = 1; rBusyN = 1; rAddr = '0; rWrData = '0;
  endtask

  task automatic driveL(input logic ce, oe, rw, busy,
                        input logic [10:0] a, input logic [7:0] d);
    lCeN = ce; lOeN = oe; lRwN = rw; lBusyN = busy; lAddr = a; lWrData = d;
  endtask

  task automatic driveR(input logic ce, oe, rw, busy,
                        input logic [10:0] a, input logic [7:0] d);
    rCeN = ce; rOeN = oe; rRwN = rw; rBusyN = busy; rAddr = a; rWrData = d;
  endtask

  task automatic readL(input logic [10:0] a, input int exp, input string req);
    driveL(0, 0, 1, 1, a, 8'h00); tick(); idleL();
    chk({req, " left read valid"}, int'(lRdValid), 1);
    chk({req, " left read data"}, int'(lRdData), exp);
  endtask

  task automatic readR(input logic [10:0] a, input int exp, input string req);
    driveR(0, 0, 1, 1, a, 8'h00); tick(); idleR();
    chk({req, " right read valid"}, int'(rRdValid), 1);
    chk({req, " right read data"}, int'(rRdData), exp);
  endtask

  task automatic t_reset();
    chk("R1 lIntN", int'(lIntN), 1);
    chk("R1 rIntN", int'(rIntN), 1);
    chk("R1 lRdValid", int'(lRdValid), 0);
    chk("R1 rRdValid", int'(rRdValid), 0);
    chk("R1 rRdData", int'(rRdData), 0);
  endtask

  task automatic t_basic();
    driveL(0, 1, 0, 1, 11'h123, 8'hA5);
    driveR(0, 1, 0, 1, 11'h045, 8'h3C);
    tick(); idleL(); idleR();
    readL(11'h045, 'h3C, "R3");
    readR(11'h123, 'hA5, "R3");
    tick();
    chk("R2 idle left valid", int'(lRdValid), 0);
    chk("R2 idle left data", int'(lRdData), 0);
    chk("R2 idle right valid", int'(rRdValid), 0);
    // write with output enable low still stores (R3)
    driveL(0, 0, 0, 1, 11'h010, 8'h77); tick(); idleL();
    chk("R2 write cycle not a read", int'(lRdValid), 0);
    readR(11'h010, 'h77, "R3 oe-low write");
    // chip enable high: nothing stored (R3)
    driveL(1, 1, 0, 1, 11'h010, 8'h11); tick(); idleL();
    readL(11'h010, 'h77, "R3 ce-high write ignored");
  endtask

  task automatic t_busyWrite();
    driveL(0, 1, 0, 0, 11'h010, 8'h22); tick(); idleL();
    readL(11'h010, 'h77, "R4 left busy");
    driveR(0, 1, 0, 0, 11'h010, 8'h33); tick(); idleR();
    readR(11'h010, 'h77, "R4 right busy");
  endtask

  task automatic t_mboxLeft();
    driveR(0, 1, 0, 1, 11'h7FE, 8'h5A); tick(); idleR();
    chk("R5 lIntN set", int'(lIntN), 0);
    chk("R5 rIntN untouched", int'(rIntN), 1);
    readL(11'h7FE, 'h5A, "R10 mailbox L");
    chk("R6 lIntN cleared by read", int'(lIntN), 1);
    driveR(0, 1, 0, 1, 11'h7FE, 8'h5B); tick(); idleR();
    chk("R5 lIntN set again", int'(lIntN), 0);
    // clear with read/write low: also a write of the mailbox
    driveL(0, 0, 0, 1, 11'h7FE, 8'h66); tick(); idleL();
    chk("R6 lIntN cleared with rw low", int'(lIntN), 1);
    readR(11'h7FE, 'h66, "R10 mailbox L rewritten");
  endtask

  task automatic t_mboxRight();
    driveL(0, 1, 0, 1, 11'h7FF, 8'h81); tick(); idleL();
    chk("R7 rIntN set", int'(rIntN), 0);
    chk("R7 lIntN untouched", int'(lIntN), 1);
    readR(11'h7FF, 'h81, "R10 mailbox R");
    chk("R7 rIntN cleared", int'(rIntN), 1);
  endtask

  task automatic t_ownBox();
    driveL(0, 1, 0, 1, 11'h7FE, 8'h12);
    driveR(0, 1, 0, 1, 11'h7FF, 8'h34);
    tick(); idleL(); idleR();
    chk("R13 left own box", int'(lIntN), 1);
    chk("R13 right own box", int'(rIntN), 1);
    readL(11'h7FF, 'h34, "R10 right box written by right");
  endtask

  task automatic t_busyFlag();
    driveR(0, 1, 0, 0, 11'h7FE, 8'h99); tick(); idleR();
    chk("R8 set blocked by busy", int'(lIntN), 1);
    driveR(0, 1, 0, 1, 11'h7FE, 8'h44); tick(); idleR();
    chk("R5 set", int'(lIntN), 0);
    driveL(0, 0, 1, 0, 11'h7FE, 8'h00); tick(); idleL();
    chk("R8 clear blocked by busy", int'(lIntN), 0);
    readL(11'h7FE, 'h44, "R6");
    chk("R6 clear after busy released", int'(lIntN), 1);
  endtask

  task automatic t_priority();
    driveR(0, 1, 0, 1, 11'h7FE, 8'hC3);
    driveL(0, 0, 1, 1, 11'h7FE, 8'h00);
    tick(); idleL(); idleR();
    chk("R9 set wins over clear", int'(lIntN), 0);
    chk("R11 reader sees old mailbox byte", int'(lRdData), 'h44);
    readL(11'h7FE, 'hC3, "R10");
    chk("R6 final clear", int'(lIntN), 1);
    driveL(0, 1, 0, 1, 11'h7FF, 8'h01);
    driveR(0, 0, 1, 1, 11'h7FF, 8'h00);
    tick(); idleL(); idleR();
    chk("R9 right set wins", int'(rIntN), 0);
    readR(11'h7FF, 'h01, "R7");
    chk("R7 right cleared", int'(rIntN), 1);
  endtask

  task automatic t_collide();
    driveL(0, 1, 0, 1, 11'h200, 8'hAA); tick(); idleL();
    driveL(0, 1, 0, 1, 11'h200, 8'hBB);
    driveR(0, 0, 1, 1, 11'h200, 8'h00);
    tick(); idleL(); idleR();
    chk("R11 old data to reader", int'(rRdData), 'hAA);
    readR(11'h200, 'hBB, "R11 new data after");
    driveR(0, 1, 0, 1, 11'h200, 8'hCD);
    driveL(0, 0, 1, 1, 11'h200, 8'h00);
    tick(); idleL(); idleR();
    chk("R11 left reader old data", int'(lRdData), 'hBB);
    driveL(0, 1, 0, 1, 11'h300, 8'h11);
    driveR(0, 1, 0, 1, 11'h300, 8'h22);
    tick(); idleL(); idleR();
    readR(11'h300, 'h11, "R12 left write kept");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idleL(); idleR();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    tick();
    t_basic();
    t_busyWrite();
    t_mboxLeft();
    t_mboxRight();
    t_ownBox();
    t_busyFlag();
    t_priority();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule